// File: doc/BRIEF.md
# Fall-Through Word Stack

This block is the storage core that sits between an input register and an output register. It holds up to fourteen 4-bit words in a column of locations. A word enters at the top location and then sinks by itself, one location per clock, until it reaches the bottom or meets a location that is still occupied. There are no read or write pointers. Each location has its own occupancy flag, and the words move through the column like beads on a string.

The input side offers a word with `push` and `push_data`. The word is taken only when `top_empty` reports that the top location is free. The output side sees the bottom location through `bottom_valid` and `bottom_data`. It pulses `pop` to take that word, which vacates the bottom so the word above can sink into it on the same edge. Reset clears only the occupancy flags. The stored data bits keep whatever values they had.

Top module: `ft_stack`

## Requirements
- R1: The stack holds exactly 14 words. After 14 accepted pushes with no pop, `top_empty` stays 0 once the column has settled, and the 14 words can all be popped.
- R2: A push is accepted at a rising clock edge only if `top_empty` is 1 before that edge. A push while `top_empty` is 0 is ignored, and its data never appears at the bottom.
- R3: A word moves down one location per clock whenever the location below is empty or is being vacated on the same edge. It stops while the location below stays occupied.
- R4: A word pushed into an empty stack makes `bottom_valid` rise 13 clock edges after the edge that accepted it.
- R5: While `bottom_valid` is 1 and `pop` is 0, `bottom_valid` and `bottom_data` hold. A pop with `bottom_valid` 1 removes that word exactly once.
- R6: A pop while `bottom_valid` is 0 is ignored. No word is lost or skipped because of it.
- R7: Words leave in the order they were accepted, for any interleaving of push and pop, including both in the same cycle.
- R8: Synchronous active-high reset sets `top_empty` to 1 and `bottom_valid` to 0 from the first edge. Stored data is untouched, so `bottom_data` keeps its value across reset.
- R9: When the column is fully packed, a pop on every cycle delivers a new valid word at the bottom on each following cycle, because the whole column shifts down together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the occupancy flags |
| push | input | 1 | Offer `push_data` to the top location |
| push_data | input | 4 | Word offered at the top |
| pop | input | 1 | Take the word at the bottom location |
| top_empty | output | 1 | Top location is free; a push is accepted at the next edge |
| bottom_valid | output | 1 | Bottom location holds a word |
| bottom_data | output | 4 | Word stored in the bottom location |

## Verification
The main function is driven in four ways. A lone word in an empty column measures the 13-edge transit and shows that the word rests at the bottom. Back-to-back pushes against a top that is still occupied separate accepted words from dropped ones. A completely packed column drained by pops on every cycle shows whether the whole column moves in lockstep or leaves bubbles. Mixed push, pop and pop-on-empty sequences are checked against an ordered queue of accepted words, which reveals any reordering, duplication or loss.

// File: rtl/ft_stack_pkg.sv
package ft_stack_pkg;

    localparam int FT_WIDTH = 4;
    localparam int FT_DEPTH = 14;

    typedef logic [FT_WIDTH-1:0] word_t;

    typedef struct packed {
        logic  full;
        word_t data;
    } slot_t;

    // A location can take a word when it is free or its word leaves this edge.
    function automatic logic slot_can_take(input slot_t s, input logic leaving);
        return !s.full || leaving;
    endfunction

endpackage

// File: rtl/ft_cell.sv
module ft_cell
    import ft_stack_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  word_t in_data,
    input  logic  out_take,
    output logic  ready,
    output slot_t state
);

    slot_t cur;
    slot_t nxt;
    logic  leaving;
    logic  taking;

    assign leaving = cur.full && out_take;
    assign ready   = slot_can_take(cur, leaving);
    assign taking  = in_valid && ready;
    assign state   = cur;

    always_comb begin
        nxt = cur;
        if (leaving) begin
            nxt.full = 1'b0;
        end
        if (taking) begin
            nxt.full = 1'b1;
            nxt.data = in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.full <= 1'b0;
        end else begin
            cur.full <= nxt.full;
            cur.data <= nxt.data;
        end
    end

    // R3: an occupied location whose word cannot move keeps that word.
    p_stall_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (cur.full && !out_take) |=> (cur.full && $stable(cur.data)));

endmodule

// File: rtl/ft_chain.sv
module ft_chain
    import ft_stack_pkg::*;
#(
    parameter int DEPTH = FT_DEPTH
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               head_valid,
    input  word_t              head_data,
    input  logic               tail_take,
    output slot_t [DEPTH-1:0]  slots
);

    localparam int LAST = DEPTH - 1;

    logic [DEPTH-1:0] rdy;

    for (genvar i = 0; i < DEPTH; i++) begin : g_loc
        logic  up_valid;
        word_t up_data;
        logic  down_take;

        if (i == 0) begin : g_head
            assign up_valid = head_valid;
            assign up_data  = head_data;
        end else begin : g_inner_in
            assign up_valid = slots[i-1].full;
            assign up_data  = slots[i-1].data;
        end

        if (i == LAST) begin : g_tail
            assign down_take = tail_take;
        end else begin : g_inner_out
            assign down_take = rdy[i+1];
        end

        ft_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .in_valid (up_valid),
            .in_data  (up_data),
            .out_take (down_take),
            .ready    (rdy[i]),
            .state    (slots[i])
        );

        if (i < LAST) begin : g_fall_chk
            // R3: a word above a free location arrives there on the next edge.
            p_fall_step_r3: assert property (@(posedge clk) disable iff (rst)
                (slots[i].full && !slots[i+1].full)
                |=> (slots[i+1].full && slots[i+1].data == $past(slots[i].data)));
        end
    end

endmodule

// File: rtl/ft_stack.sv
module ft_stack
    import ft_stack_pkg::*;
#(
    parameter int DEPTH = FT_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [FT_WIDTH-1:0] push_data,
    input  logic              pop,
    output logic              top_empty,
    output logic              bottom_valid,
    output logic [FT_WIDTH-1:0] bottom_data
);

    localparam int LAST = DEPTH - 1;

    slot_t [DEPTH-1:0] slots;
    logic              head_valid;

    assign top_empty    = !slots[0].full;
    assign head_valid   = push && top_empty;
    assign bottom_valid = slots[LAST].full;
    assign bottom_data  = slots[LAST].data;

    ft_chain #(
        .DEPTH (DEPTH)
    ) u_chain (
        .clk        (clk),
        .rst        (rst),
        .head_valid (head_valid),
        .head_data  (push_data),
        .tail_take  (pop),
        .slots      (slots)
    );

    // R2: an occupied top either keeps its word or empties; no push lands on it.
    p_top_guard_r2: assert property (@(posedge clk) disable iff (rst)
        !top_empty |=> (top_empty || $stable(slots[0].data)));

    // R5: the bottom word stays put until it is popped.
    p_bottom_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (bottom_valid && !pop) |=> (bottom_valid && $stable(bottom_data)));

    // R8: leaving reset, the column is empty.
    p_reset_empty_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (top_empty && !bottom_valid));

    // R6: a pop on an empty bottom cannot create a word above it in the top slot.
    p_pop_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (!bottom_valid && pop && top_empty && !push) |=> top_empty);

endmodule

// File: tb/ft_stack_tb.sv
module ft_stack_tb;
    import ft_stack_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = FT_DEPTH;
    localparam int NVEC       = 24;

    typedef struct packed {
        logic       push;
        logic [3:0] data;
        logic       pop;
        logic [4:0] idle;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 4'h1, 1'b0, 5'd0},
        '{1'b1, 4'h2, 1'b0, 5'd0},
        '{1'b1, 4'h3, 1'b0, 5'd0},
        '{1'b1, 4'h4, 1'b0, 5'd0},
        '{1'b1, 4'h5, 1'b0, 5'd16},
        '{1'b0, 4'h0, 1'b1, 5'd0},
        '{1'b1, 4'h6, 1'b1, 5'd0},
        '{1'b0, 4'h0, 1'b1, 5'd0},
        '{1'b0, 4'h0, 1'b1, 5'd0},
        '{1'b0, 4'h0, 1'b1, 5'd0},
        '{1'b0, 4'h0, 1'b1, 5'd20},
        '{1'b0, 4'h0, 1'b1, 5'd2},
        '{1'b1, 4'h7, 1'b0, 5'd1},
        '{1'b1, 4'h8, 1'b0, 5'd1},
        '{1'b1, 4'h9, 1'b0, 5'd1},
        '{1'b1, 4'hA, 1'b1, 5'd1},
        '{1'b1, 4'hB, 1'b1, 5'd1},
        '{1'b1, 4'hC, 1'b0, 5'd18},
        '{1'b1, 4'hD, 1'b1, 5'd0},
        '{1'b0, 4'h0, 1'b1, 5'd0},
        '{1'b0, 4'h0, 1'b1, 5'd0},
        '{1'b1, 4'hE, 1'b1, 5'd3},
        '{1'b0, 4'h0, 1'b1, 5'd0},
        '{1'b0, 4'h0, 1'b1, 5'd20}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       push;
    logic [3:0] push_data;
    logic       pop;
    logic       top_empty;
    logic       bottom_valid;
    logic [3:0] bottom_data;

    int         n_vec  = 0;
    int         n_miss = 0;
    bit         done   = 0;
    logic [3:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ft_stack #(.DEPTH(DEPTH)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .push         (push),
        .push_data    (push_data),
        .pop          (pop),
        .top_empty    (top_empty),
        .bottom_valid (bottom_valid),
        .bottom_data  (bottom_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_miss++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one cycle at the falling edge; outputs seen here hold until the next rising edge.
    task automatic step(input logic p, input logic [3:0] d, input logic q);
        @(negedge clk);
        push      = p;
        push_data = d;
        pop       = q;
        if (p && top_empty) exp_q.push_back(d);
        if (q && bottom_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected word", int'(bottom_data), 0);
            end else begin
                chk(bottom_data == exp_q[0], "R7 order", int'(bottom_data), int'(exp_q[0]));
                void'(exp_q.pop_front());
            end
        end
    endtask

    task automatic do_reset(input int cycles);
        @(negedge clk);
        rst = 1'b1; push = 1'b0; pop = 1'b0;
        repeat (cycles) @(negedge clk);
        rst = 1'b0;
        exp_q.delete();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin
        logic [3:0] kept;
        int         accepted;
        rst = 1'b1; push = 1'b0; push_data = 4'h0; pop = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R8: state right after reset
        chk(top_empty == 1'b1, "R8 top_empty after reset", top_empty, 1);
        chk(bottom_valid == 1'b0, "R8 bottom_valid after reset", bottom_valid, 0);

        // R4: transit time of a lone word, R6: pop on empty during transit
        step(1'b1, 4'h5, 1'b0);
        for (int k = 1; k <= 14; k++) begin
            step(1'b0, 4'h0, (k == 5));
            if (k == 13) chk(bottom_valid == 1'b0, "R4 not yet at bottom", bottom_valid, 0);
            if (k == 14) begin
                chk(bottom_valid == 1'b1, "R4 arrives after 13 edges", bottom_valid, 1);
                chk(bottom_data == 4'h5, "R6 word survives early pop", bottom_data, 5);
            end
        end
        // R5: held while not popped
        repeat (3) step(1'b0, 4'h0, 1'b0);
        chk(bottom_valid && bottom_data == 4'h5, "R5 bottom holds", bottom_data, 5);
        step(1'b0, 4'h0, 1'b1);
        step(1'b0, 4'h0, 1'b0);
        chk(bottom_valid == 1'b0, "R5 popped once", bottom_valid, 0);

        // R1: fill to capacity
        accepted = 0;
        for (int t = 0; t < 200 && accepted < DEPTH; t++) begin
            @(negedge clk);
            push = 1'b1; push_data = 4'(accepted); pop = 1'b0;
            if (top_empty) begin
                exp_q.push_back(4'(accepted));
                accepted++;
            end
        end
        repeat (30) step(1'b0, 4'h0, 1'b0);
        chk(top_empty == 1'b0, "R1 full after 14 words", top_empty, 0);
        chk(bottom_valid == 1'b1, "R1 bottom occupied", bottom_valid, 1);
        // R2: pushes into a full top are dropped
        repeat (3) step(1'b1, 4'hF, 1'b0);
        chk(exp_q.size() == DEPTH, "R2 queue unchanged", exp_q.size(), DEPTH);
        // R9: lockstep drain
        for (int k = 0; k < DEPTH; k++) begin
            chk(bottom_valid == 1'b1, "R9 bottom refilled each cycle", bottom_valid, 1);
            step(1'b0, 4'h0, 1'b1);
        end
        step(1'b0, 4'h0, 1'b0);
        chk(bottom_valid == 1'b0, "R2 no dropped word appears", bottom_valid, 0);
        chk(top_empty == 1'b1, "R1 empty after drain", top_empty, 1);

        // R8: reset keeps stored data
        step(1'b1, 4'h9, 1'b0);
        repeat (16) step(1'b0, 4'h0, 1'b0);
        kept = bottom_data;
        chk(kept == 4'h9, "R8 word at bottom before reset", kept, 9);
        do_reset(2);
        chk(bottom_valid == 1'b0, "R8 reset clears occupancy", bottom_valid, 0);
        chk(top_empty == 1'b1, "R8 reset frees top", top_empty, 1);
        chk(bottom_data == kept, "R8 data retained", bottom_data, kept);

        // R3, R5, R6, R7: vector table
        for (int i = 0; i < NVEC; i++) begin
            step(VECS[i].push, VECS[i].data, VECS[i].pop);
            for (int w = 0; w < int'(VECS[i].idle); w++) step(1'b0, 4'h0, 1'b0);
        end
        for (int t = 0; t < 80 && exp_q.size() > 0; t++) step(1'b0, 4'h0, 1'b1);
        step(1'b0, 4'h0, 1'b0);
        chk(exp_q.size() == 0, "R7 all accepted words delivered", exp_q.size(), 0);
        chk(bottom_valid == 1'b0, "R3 column empty at end", bottom_valid, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

endmodule